// File: doc/BRIEF.md
# Vectored Priority Interrupt Collector

This block gathers 64 interrupt request lines into one CPU interrupt output. Every source has a 2-bit priority, an enable and a software-trigger flag. The collector picks the most urgent pending source and shows the handler address for it: a programmable table base plus four times the source number. It also records which priority levels are currently being serviced. Software sees the block through a 32-bit register bus with read and write strobes and a word address. Every register offers four write forms: replace, OR-in, clear-bits and toggle.

A handler reaches the service state in one of two ways, chosen by a control bit. It either writes the vector register or, in read-entry mode, reads it. At the end of the handler, software retires the level it served by writing that level's bit to the acknowledge register. Nested service of a strictly more urgent level is allowed unless a control bit turns nesting off.

The sequencing lives in a three-state machine:
- `S_IDLE`: nothing is in service and nothing is raised.
- `S_REQ`: the IRQ output is high.
- `S_SERVE`: at least one level is in service and no new IRQ is raised.

Its transitions are:
- Raise: `S_IDLE` to `S_REQ`.
- Enter: `S_REQ` to `S_SERVE`.
- Withdraw: `S_REQ` to `S_IDLE` or `S_SERVE`, when the request vanishes before entry.
- Nest: `S_SERVE` to `S_REQ`.
- Retire: `S_SERVE` to `S_IDLE`, once the last level is acknowledged.

Top module: `irq_collector`

## Requirements
- R1: Register word index is byte address bits 8:4 and the write form is bits 3:2. Form 0 replaces, 1 ORs in the data, 2 clears the set data bits and 3 toggles them. The scratch register at 0x1F0 keeps all 32 bits.
- R2: Reads at 0x40 return request lines 31..0 and reads at 0x50 return lines 63..32. Writes to these two addresses change nothing.
- R3: Source n is configured in the word at 0x60 + 0x10*(n/4), in the byte at bit 8*(n mod 4). In that byte, bits 1:0 are the priority, bit 2 the enable and bit 3 the software trigger. Bits 7:4 of each byte read as zero.
- R4: A source is pending when it is enabled and either its line or its trigger is high. The IRQ output goes high one clock after an eligible pending source appears. It never goes high while control bit 16 is 0.
- R5: Among pending sources the highest priority wins, and equal priorities go to the lowest source number.
- R6: Offset 0x160 holds table-base bits 31:2, and bits 1:0 read as zero. The vector register at 0x00 reads base + 4*source. The status register at 0x30 returns the source number in bits 5:0.
- R7: With control bit 18 at 0, a write to 0x00 while the IRQ is high puts the winner's level in service and drops the IRQ. A read of 0x00 does not.
- R8: With control bit 18 at 1, a read of 0x00 while the IRQ is high enters service. A write to 0x00 does not.
- R9: With nesting allowed, the IRQ is raised while levels are in service only if the winner's priority is strictly above every in-service level. The vector then shows the new winner.
- R10: With control bit 19 at 1, no IRQ is raised while any level is in service.
- R11: Writing 0x10 with bit L set retires level L. Bits for levels not in service have no effect. While serving, vector and status hold the source of the highest in-service level until that level is retired.
- R12: Writing a 1 to bit k at 0x1D0 or 0x1E0 clears the software trigger of source k or 32+k respectively. Both addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 7 | Byte address bits 8:2 |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid combinationally in the strobe cycle |
| irq_lines | input | 64 | Raw interrupt request lines, level sensitive |
| cpu_irq | output | 1 | Interrupt request to the CPU |

## Verification
Arbitration is exercised with three patterns:
- A single line-driven source.
- A tie between equal priorities on a low and a high source number, which exposes a wrong tie-break direction.
- A top-priority software trigger that overtakes both tied sources, which separates priority order from index order.

Entry, nesting and acknowledge are driven in both entry modes. A write must enter in one mode and a read in the other, and the opposite action must leave the IRQ up. An acknowledge of a level not in service must leave the held vector untouched. A nested level-3 service above level 1 must restore the level-1 vector on retire. The same more-urgent trigger is then repeated with nesting off, where it must stay masked until retire.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int PRIO_W = 2;

    // word indices (byte address bits 8:4)
    localparam logic [4:0] IDX_VECTOR  = 5'd0;
    localparam logic [4:0] IDX_ACK     = 5'd1;
    localparam logic [4:0] IDX_CTRL    = 5'd2;
    localparam logic [4:0] IDX_STAT    = 5'd3;
    localparam logic [4:0] IDX_RAW_LO  = 5'd4;
    localparam logic [4:0] IDX_RAW_HI  = 5'd5;
    localparam logic [4:0] IDX_SRC0    = 5'd6;
    localparam logic [4:0] IDX_BASE    = 5'd22;
    localparam logic [4:0] IDX_CLR0    = 5'd29;
    localparam logic [4:0] IDX_SCRATCH = 5'd31;

    // control bit positions
    localparam int CTRL_IRQ_EN   = 16;
    localparam int CTRL_RD_ENTRY = 18;
    localparam int CTRL_NO_NEST  = 19;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_REQ   = 2'd1,
        S_SERVE = 2'd2
    } svc_state_t;

    typedef enum logic [1:0] {
        OP_REPLACE = 2'd0,
        OP_OR      = 2'd1,
        OP_CLEAR   = 2'd2,
        OP_TOGGLE  = 2'd3
    } wr_form_t;

    function automatic logic [31:0] merge_write(input logic [31:0] cur,
                                                input logic [31:0] data,
                                                input wr_form_t form);
        logic [31:0] r;
        unique case (form)
            OP_REPLACE: r = data;
            OP_OR:      r = cur | data;
            OP_CLEAR:   r = cur & ~data;
            OP_TOGGLE:  r = cur ^ data;
            default:    r = cur;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/irqc_pick.sv
module irqc_pick
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 64,
    localparam int SRC_W = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]        pend,
    input  logic [NUM_SRC*PRIO_W-1:0] prio,
    output logic                      any,
    output logic [SRC_W-1:0]          win_id,
    output logic [PRIO_W-1:0]         win_lvl
);

    // scan downward; ">=" lets a lower index take over a tie
    always_comb begin
        any     = 1'b0;
        win_id  = '0;
        win_lvl = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend[i] && (!any || prio[i*PRIO_W +: PRIO_W] >= win_lvl)) begin
                any     = 1'b1;
                win_id  = SRC_W'(i);
                win_lvl = prio[i*PRIO_W +: PRIO_W];
            end
        end
    end

    // R5: a reported winner is always a pending source
    always_comb begin
        if (any) begin
            p_win_pending_r5: assert (pend[win_id]);
        end
    end

endmodule

// File: rtl/irqc_service.sv
module irqc_service
    import irqc_pkg::*;
#(
    parameter int SRC_W = 6,
    localparam int NUM_LVL = 1 << PRIO_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               any,
    input  logic [SRC_W-1:0]   win_id,
    input  logic [PRIO_W-1:0]  win_lvl,
    input  logic               irq_en,
    input  logic               nest_dis,
    input  logic               enter_evt,
    input  logic [NUM_LVL-1:0] ack_mask,
    output logic               cpu_irq,
    output logic [SRC_W-1:0]   vec_src
);

    svc_state_t         st_q, st_d;
    logic [NUM_LVL-1:0] insvc_q;
    logic [SRC_W-1:0]   slot_q [NUM_LVL];
    logic               busy, blocked, eligible, entering;
    logic [NUM_LVL-1:0] lvl_bit;
    logic [SRC_W-1:0]   top_src;

    assign busy     = |insvc_q;
    assign blocked  = |(insvc_q >> win_lvl);
    assign eligible = any && irq_en && (nest_dis ? !busy : !blocked);
    assign entering = (st_q == S_REQ) && enter_evt && eligible;
    assign lvl_bit  = NUM_LVL'(1) << win_lvl;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // transitions: raise, enter, withdraw, nest, retire
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:  if (eligible) st_d = S_REQ;
            S_REQ: begin
                if (entering)       st_d = S_SERVE;
                else if (!eligible) st_d = busy ? S_SERVE : S_IDLE;
            end
            S_SERVE: begin
                if (eligible)       st_d = S_REQ;
                else if (!busy)     st_d = S_IDLE;
            end
            default: st_d = S_IDLE;
        endcase
    end

    // in-service levels and the source held for each level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            insvc_q <= '0;
            for (int l = 0; l < NUM_LVL; l++) slot_q[l] <= '0;
        end else begin
            insvc_q <= (insvc_q & ~ack_mask) | (entering ? lvl_bit : '0);
            if (entering) slot_q[win_lvl] <= win_id;
        end
    end

    // outputs
    always_comb begin
        top_src = win_id;
        for (int l = 0; l < NUM_LVL; l++) begin
            if (insvc_q[l]) top_src = slot_q[l];
        end
        cpu_irq = (st_q == S_REQ);
        vec_src = (st_q == S_REQ || !busy) ? win_id : top_src;
    end

    // R4: the output only rises out of an enabled cycle
    p_irq_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> $past(irq_en));

    // R10: nothing raised on top of service when nesting is off
    p_no_nest_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_irq && $past(nest_dis)) |-> ($past(insvc_q) == '0));

    // R11: an in-service level only leaves through its acknowledge bit
    p_ack_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(insvc_q) & ~insvc_q & ~$past(ack_mask)) == '0));

    // R7: at most one level enters per cycle
    p_single_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(insvc_q & ~$past(insvc_q)));

    // R11: held vector while service is unchanged
    p_vec_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_SERVE && $past(st_q) == S_SERVE && $stable(insvc_q))
            |-> $stable(vec_src));

endmodule

// File: rtl/irq_collector.sv
module irq_collector
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 64,
    localparam int SRC_W = $clog2(NUM_SRC),
    localparam int NUM_CW = NUM_SRC / 4,
    localparam int CW_W = $clog2(NUM_CW),
    localparam int NUM_LVL = 1 << PRIO_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [8:2]         bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_SRC-1:0] irq_lines,
    output logic               cpu_irq
);

    logic [4:0]   idx;
    wr_form_t     form;
    logic [31:0]  ctrl_q, scratch_q;
    logic [29:0]  base_q;
    logic [31:0]  ctrl_nx, scratch_nx, base_nx;
    logic [63:0]  raw_pad;
    logic [NUM_SRC*4-1:0]      cfg_flat;
    logic [31:0]               cfg_word [NUM_CW];
    logic [NUM_SRC-1:0]        pend;
    logic [NUM_SRC*PRIO_W-1:0] prio;
    logic                      any, enter_evt;
    logic [SRC_W-1:0]          win_id, vec_src;
    logic [PRIO_W-1:0]         win_lvl;
    logic [NUM_LVL-1:0]        ack_mask;
    logic [CW_W-1:0]           cw_idx;

    assign idx     = bus_addr[8:4];
    assign form    = wr_form_t'(bus_addr[3:2]);
    assign raw_pad = 64'(irq_lines);
    assign cw_idx  = CW_W'(idx - IDX_SRC0);

    assign ctrl_nx    = merge_write(ctrl_q, bus_wdata, form);
    assign scratch_nx = merge_write(scratch_q, bus_wdata, form);
    assign base_nx    = merge_write({base_q, 2'b00}, bus_wdata, form);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            scratch_q <= '0;
            base_q    <= '0;
        end else if (bus_wr) begin
            if (idx == IDX_CTRL)    ctrl_q    <= ctrl_nx;
            if (idx == IDX_SCRATCH) scratch_q <= scratch_nx;
            if (idx == IDX_BASE)    base_q    <= base_nx[31:2];
        end
    end

    // per-source configuration nibble {trigger, enable, priority}
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        localparam int W  = s / 4;
        localparam int SL = s % 4;
        logic [3:0]  cfg_q;
        logic [31:0] merged;
        assign merged = merge_write(cfg_word[W], bus_wdata, form);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q <= '0;
            end else if (bus_wr && idx == IDX_SRC0 + 5'(W)) begin
                cfg_q <= merged[SL*8 +: 4];
            end else if (bus_wr && idx == IDX_CLR0 + 5'(s / 32) && bus_wdata[s % 32]) begin
                cfg_q[3] <= 1'b0;
            end
        end
        assign cfg_flat[s*4 +: 4]        = cfg_q;
        assign pend[s]                   = cfg_q[2] & (irq_lines[s] | cfg_q[3]);
        assign prio[s*PRIO_W +: PRIO_W]  = cfg_q[1:0];
    end

    for (genvar w = 0; w < NUM_CW; w++) begin : g_word
        for (genvar k = 0; k < 4; k++) begin : g_slot
            assign cfg_word[w][k*8 +: 8] = {4'b0000, cfg_flat[(w*4+k)*4 +: 4]};
        end
    end

    assign enter_evt = ctrl_q[CTRL_RD_ENTRY] ? (bus_rd && idx == IDX_VECTOR)
                                             : (bus_wr && idx == IDX_VECTOR);
    assign ack_mask  = (bus_wr && idx == IDX_ACK) ? bus_wdata[NUM_LVL-1:0] : '0;

    irqc_pick #(.NUM_SRC(NUM_SRC)) u_pick (
        .pend    (pend),
        .prio    (prio),
        .any     (any),
        .win_id  (win_id),
        .win_lvl (win_lvl)
    );

    irqc_service #(.SRC_W(SRC_W)) u_svc (
        .clk       (clk),
        .rst_n     (rst_n),
        .any       (any),
        .win_id    (win_id),
        .win_lvl   (win_lvl),
        .irq_en    (ctrl_q[CTRL_IRQ_EN]),
        .nest_dis  (ctrl_q[CTRL_NO_NEST]),
        .enter_evt (enter_evt),
        .ack_mask  (ack_mask),
        .cpu_irq   (cpu_irq),
        .vec_src   (vec_src)
    );

    always_comb begin
        bus_rdata = '0;
        case (idx)
            IDX_VECTOR:  bus_rdata = {base_q, 2'b00} + (32'(vec_src) << 2);
            IDX_CTRL:    bus_rdata = ctrl_q;
            IDX_STAT:    bus_rdata = 32'(vec_src);
            IDX_RAW_LO:  bus_rdata = raw_pad[31:0];
            IDX_RAW_HI:  bus_rdata = raw_pad[63:32];
            IDX_BASE:    bus_rdata = {base_q, 2'b00};
            IDX_SCRATCH: bus_rdata = scratch_q;
            default: begin
                if (idx >= IDX_SRC0 && idx < IDX_SRC0 + 5'(NUM_CW))
                    bus_rdata = cfg_word[cw_idx];
            end
        endcase
    end

    // R6: the vector value never carries low address bits
    p_vec_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && idx == IDX_VECTOR) |-> (bus_rdata[1:0] == 2'b00));

endmodule

// File: tb/sim_irq_collector.sv
module sim_irq_collector;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct {
        string       tag;
        bit          is_irq;
        logic [31:0] exp;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:2]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] irq_lines = '0;
    logic        cpu_irq;
    logic        irq_probe = 1'b0;

    item_t q[$];
    int    n_checks = 0;
    int    n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_collector u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_lines (irq_lines),
        .cpu_irq   (cpu_irq)
    );

    task automatic bus_write(input logic [8:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_addr = a[8:2]; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic expect_read(input logic [8:0] a, input logic [31:0] e, input string tag);
        @(posedge clk); #1;
        q.push_back('{tag: tag, is_irq: 1'b0, exp: e});
        bus_addr = a[8:2]; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic expect_irq(input logic e, input string tag);
        @(posedge clk); #1;
        q.push_back('{tag: tag, is_irq: 1'b1, exp: {31'b0, e}});
        irq_probe = 1'b1;
        @(posedge clk); #1;
        irq_probe = 1'b0;
    endtask

    // monitor: compares design output against the scoreboard head
    always @(negedge clk) begin
        if (bus_rd || irq_probe) begin : mon
            item_t       it;
            logic [31:0] act;
            if (q.size() == 0) begin
                n_checks++; n_fails++;
                $display("FAIL scoreboard empty, actual=sample expected=item");
            end else begin
                it  = q.pop_front();
                act = it.is_irq ? {31'b0, cpu_irq} : bus_rdata;
                n_checks++;
                if (act !== it.exp) begin
                    n_fails++;
                    $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // reset state
        expect_irq(1'b0, "R4");
        expect_read(9'h1F0, 32'h0, "R1");

        // R1: four write forms on the scratch register
        bus_write(9'h1F0, 32'h0000_00F0);
        expect_read(9'h1F0, 32'h0000_00F0, "R1");
        bus_write(9'h1F4, 32'h0000_000F);
        expect_read(9'h1F0, 32'h0000_00FF, "R1");
        bus_write(9'h1F8, 32'h0000_0030);
        expect_read(9'h1F0, 32'h0000_00CF, "R1");
        bus_write(9'h1FC, 32'h0000_0101);
        expect_read(9'h1F0, 32'h0000_01CE, "R1");

        // R2: raw line view, read only
        irq_lines = 64'hA5A5_0001_8000_0003;
        expect_read(9'h040, 32'h8000_0003, "R2");
        expect_read(9'h050, 32'hA5A5_0001, "R2");
        bus_write(9'h040, 32'h0000_FFFF);
        expect_read(9'h040, 32'h8000_0003, "R2");
        irq_lines = '0;

        // R3: configuration slots, upper nibble of each byte dropped
        bus_write(9'h080, 32'h1234_5678);
        expect_read(9'h080, 32'h0204_0608, "R3");
        bus_write(9'h080, 32'h0);
        expect_read(9'h080, 32'h0, "R3");

        // R4: source 5, priority 1, enabled, line high; global enable off
        bus_write(9'h070, 32'h0000_0500);
        irq_lines[5] = 1'b1;
        expect_irq(1'b0, "R4");
        bus_write(9'h024, 32'h0001_0000);
        expect_irq(1'b1, "R4");

        // R6: base and vector
        bus_write(9'h160, 32'h1000_0003);
        expect_read(9'h160, 32'h1000_0000, "R6");
        expect_read(9'h000, 32'h1000_0014, "R6");
        expect_read(9'h030, 32'd5, "R6");
        // R7: a read in write-entry mode does not enter service
        expect_irq(1'b1, "R7");

        // R5: tie with source 40, then a top-priority trigger on source 63
        bus_write(9'h100, 32'h0000_000D);
        expect_read(9'h030, 32'd5, "R5");
        bus_write(9'h150, 32'h0F00_0000);
        expect_read(9'h030, 32'd63, "R5");
        // R12: clear trigger of source 63
        bus_write(9'h1E0, 32'h8000_0000);
        expect_read(9'h030, 32'd5, "R12");
        expect_read(9'h150, 32'h0700_0000, "R12");
        expect_read(9'h1E0, 32'h0, "R12");

        // R7: write to vector enters level 1
        bus_write(9'h000, 32'h0);
        expect_irq(1'b0, "R7");
        expect_read(9'h000, 32'h1000_0014, "R7");

        // R9: level 3 nests over level 1
        bus_write(9'h154, 32'h0800_0000);
        expect_irq(1'b1, "R9");
        expect_read(9'h030, 32'd63, "R9");
        bus_write(9'h000, 32'h0);
        expect_irq(1'b0, "R9");

        // R11: acknowledging a level not in service changes nothing
        bus_write(9'h010, 32'h0000_0001);
        expect_read(9'h030, 32'd63, "R11");
        expect_irq(1'b0, "R11");
        bus_write(9'h1E0, 32'h8000_0000);
        expect_read(9'h030, 32'd63, "R11");
        bus_write(9'h010, 32'h0000_0008);
        expect_read(9'h030, 32'd5, "R11");
        expect_irq(1'b0, "R11");
        bus_write(9'h010, 32'h0000_0002);
        expect_irq(1'b1, "R11");

        // R8: read-entry mode
        bus_write(9'h024, 32'h0004_0000);
        bus_write(9'h000, 32'h0);
        expect_irq(1'b1, "R8");
        expect_read(9'h000, 32'h1000_0014, "R8");
        expect_irq(1'b0, "R8");
        bus_write(9'h010, 32'h0000_0002);
        expect_irq(1'b1, "R8");

        // R10: nesting disabled
        bus_write(9'h024, 32'h0008_0000);
        expect_read(9'h000, 32'h1000_0014, "R10");
        bus_write(9'h154, 32'h0800_0000);
        expect_irq(1'b0, "R10");
        bus_write(9'h010, 32'h0000_0002);
        expect_irq(1'b1, "R10");
        expect_read(9'h030, 32'd63, "R10");

        repeat (2) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule